// File: doc/BRIEF.md
# Interrupt Trap Decision and Priority

This block sits beside the machine-level interrupt registers of a processor core. Each cycle it looks at the effective pending vector, the enable vector, the delegation mask, the current privilege mode and the global machine interrupt-enable bit. From these it decides whether an interrupt must be taken to machine mode and, if so, which cause number wins. The result is held in registers, so the outputs reflect the inputs of the cycle in which the decision was last refreshed.

A refresh happens in two cases. The first is any rise or fall of a pending bit. The second is a single-cycle recheck pulse, which the core raises after a return-from-trap or after a write to the pending, enable, status or delegation register. Between refreshes the decision stays frozen. The block also reports whether any enabled, pending interrupt has been handed down to supervisor level through the delegation mask. Non-maskable interrupts never reach this block. The pending-vector width `N_IRQ` must be at least 16.

Top module: `irq_trap_decide`

## Requirements
- R1: The privilege gate is open when the mode is user (2'b00), supervisor (2'b01) or the unused code 2'b10, whatever the value of `mie_i`. In machine mode (2'b11) the gate is open only when `mie_i` is 1. While the gate is closed, `take_o` stays 0.
- R2: An interrupt at bit i can be taken only if bit i is 1 in both `pend_i` and `en_i`.
- R3: A bit that is 1 in `deleg_i` is never taken to machine mode. `dpend_o` is 1 exactly when some bit is 1 in all three of `pend_i`, `en_i` and `deleg_i`, whatever the mode.
- R4: Among eligible standard causes, priority from highest to lowest is bit 11, bit 3, bit 7, bit 9, bit 1, bit 5, bit 13.
- R5: Any eligible bit at index 16 or above wins over every standard cause. Among such bits, the highest index wins.
- R6: Bits 0, 2, 4, 6, 8, 10, 12, 14 and 15 are never taken, even when pending, enabled and undelegated.
- R7: When `pend_i` differs from its value in the previous cycle, or `recheck_i` is 1, the outputs take the decision for that cycle's inputs at the next rising clock edge.
- R8: When `pend_i` is unchanged from the previous cycle and `recheck_i` is 0, the outputs hold their values, even if `en_i`, `deleg_i`, `priv_i` or `mie_i` change.
- R9: `cause_o` is 0 whenever `take_o` is 0. After reset, `take_o`, `cause_o` and `dpend_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | N_IRQ | Effective pending vector |
| en_i | input | N_IRQ | Interrupt enable vector |
| deleg_i | input | N_IRQ | Delegation mask, 1 = handed to supervisor |
| priv_i | input | 2 | Current privilege mode: 00 user, 01 supervisor, 11 machine |
| mie_i | input | 1 | Global machine interrupt-enable bit |
| recheck_i | input | 1 | Pulse after a return-from-trap or a write to a register the decision depends on |
| take_o | output | 1 | Take an interrupt to machine mode |
| cause_o | output | 6 | Selected cause number, 0 when nothing is taken |
| dpend_o | output | 1 | Some enabled, pending interrupt is delegated |

## Verification
The bench walks the full standard ranking by removing the current winner one cause at a time. An arbiter that used plain bit-index priority would report bit 13 or bit 11 in the wrong places.

It raises platform bits together with the top standard cause. A design that ranked platform causes below the standard ones, or picked the lowest platform index, would report cause 11 or 20 instead of 31. It asserts the unlisted standard bits on their own; a permissive arbiter would report a cause for them.

The refresh rules get the most attention. The bench changes the enable vector, the delegation mask and the mode with no pending edge and no recheck, and a design that re-evaluated every cycle would drop `take_o` too early. It then shows that a pending rise or fall alone refreshes the outputs, which a design that waited only for recheck would miss.

// File: rtl/irq_trap_pkg.sv
package irq_trap_pkg;

  localparam int CAUSE_W   = 6;
  localparam int STD_W     = 16;
  localparam int PLAT_BASE = 16;
  localparam int STD_N     = 7;

  typedef enum logic [1:0] {
    PRIV_U    = 2'b00,
    PRIV_S    = 2'b01,
    PRIV_RSVD = 2'b10,
    PRIV_M    = 2'b11
  } priv_e;

  // Standard causes, index 0 is the highest rank.
  localparam logic [CAUSE_W-1:0] STD_RANK [0:STD_N-1] = '{
    6'd11, 6'd3, 6'd7, 6'd9, 6'd1, 6'd5, 6'd13
  };

  typedef struct packed {
    logic               take;
    logic [CAUSE_W-1:0] cause;
    logic               dpend;
  } decision_t;

  function automatic logic [STD_W-1:0] std_mask();
    logic [STD_W-1:0] m;
    m = '0;
    for (int k = 0; k < STD_N; k++) m[STD_RANK[k][3:0]] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irq_gate.sv
module irq_gate
  import irq_trap_pkg::*;
#(
  parameter int N_IRQ = 32
) (
  input  logic [N_IRQ-1:0] pend,
  input  logic [N_IRQ-1:0] en,
  input  logic [N_IRQ-1:0] deleg,
  input  logic [1:0]       priv,
  input  logic             mie,
  output logic [N_IRQ-1:0] elig,
  output logic             dpend
);

  priv_e            mode;
  logic             gate_open;
  logic [N_IRQ-1:0] armed;

  always_comb begin
    mode      = priv_e'(priv);
    gate_open = (mode == PRIV_M) ? mie : 1'b1;
    armed     = pend & en;
    elig      = gate_open ? (armed & ~deleg) : '0;
    dpend     = |(armed & deleg);
  end

endmodule

// File: rtl/irq_std_arb.sv
module irq_std_arb
  import irq_trap_pkg::*;
(
  input  logic [STD_W-1:0]   elig,
  output logic               hit,
  output logic [CAUSE_W-1:0] cause
);

  localparam logic [STD_W-1:0] MASK = std_mask();

  logic [STD_W-1:0] valid;

  always_comb begin
    valid = elig & MASK;
    hit   = 1'b0;
    cause = '0;
    // walk from lowest rank upward so the highest rank is written last
    for (int k = STD_N - 1; k >= 0; k--) begin
      if (valid[STD_RANK[k][3:0]]) begin
        hit   = 1'b1;
        cause = STD_RANK[k];
      end
    end
  end

endmodule

// File: rtl/irq_plat_arb.sv
module irq_plat_arb
  import irq_trap_pkg::*;
#(
  parameter int W    = 16,
  parameter int BASE = 16
) (
  input  logic [W-1:0]       elig,
  output logic               hit,
  output logic [CAUSE_W-1:0] cause
);

  always_comb begin
    hit   = 1'b0;
    cause = '0;
    // ascending walk: the highest set index is written last
    for (int i = 0; i < W; i++) begin
      if (elig[i]) begin
        hit   = 1'b1;
        cause = CAUSE_W'(BASE + i);
      end
    end
  end

endmodule

// File: rtl/irq_refresh.sv
module irq_refresh #(
  parameter int N_IRQ = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] pend,
  input  logic             recheck,
  output logic             upd
);

  logic [N_IRQ-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend;
  end

  assign upd = recheck | (pend != pend_q);

endmodule

// File: rtl/irq_trap_decide.sv
module irq_trap_decide
  import irq_trap_pkg::*;
#(
  parameter int N_IRQ = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_IRQ-1:0]     pend_i,
  input  logic [N_IRQ-1:0]     en_i,
  input  logic [N_IRQ-1:0]     deleg_i,
  input  logic [1:0]           priv_i,
  input  logic                 mie_i,
  input  logic                 recheck_i,
  output logic                 take_o,
  output logic [CAUSE_W-1:0]   cause_o,
  output logic                 dpend_o
);

  localparam int PLAT_W = N_IRQ - PLAT_BASE;

  logic [N_IRQ-1:0]   elig;
  logic               dpend_c;
  logic               std_hit;
  logic [CAUSE_W-1:0] std_cause;
  logic               plat_hit;
  logic [CAUSE_W-1:0] plat_cause;
  logic               upd;
  decision_t          dec_d;
  decision_t          dec_q;

  irq_gate #(.N_IRQ(N_IRQ)) u_gate (
    .pend  (pend_i),
    .en    (en_i),
    .deleg (deleg_i),
    .priv  (priv_i),
    .mie   (mie_i),
    .elig  (elig),
    .dpend (dpend_c)
  );

  irq_std_arb u_std (
    .elig  (elig[STD_W-1:0]),
    .hit   (std_hit),
    .cause (std_cause)
  );

  generate
    if (PLAT_W > 0) begin : g_plat
      irq_plat_arb #(.W(PLAT_W), .BASE(PLAT_BASE)) u_plat (
        .elig  (elig[N_IRQ-1:PLAT_BASE]),
        .hit   (plat_hit),
        .cause (plat_cause)
      );
    end else begin : g_no_plat
      assign plat_hit   = 1'b0;
      assign plat_cause = '0;
    end
  endgenerate

  irq_refresh #(.N_IRQ(N_IRQ)) u_refresh (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend    (pend_i),
    .recheck (recheck_i),
    .upd     (upd)
  );

  // next-state: platform causes outrank the standard set
  always_comb begin
    dec_d.dpend = dpend_c;
    if (plat_hit) begin
      dec_d.take  = 1'b1;
      dec_d.cause = plat_cause;
    end else if (std_hit) begin
      dec_d.take  = 1'b1;
      dec_d.cause = std_cause;
    end else begin
      dec_d.take  = 1'b0;
      dec_d.cause = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   dec_q <= '0;
    else if (upd) dec_q <= dec_d;
  end

  assign take_o  = dec_q.take;
  assign cause_o = dec_q.cause;
  assign dpend_o = dec_q.dpend;

endmodule

// File: rtl/irq_trap_decide_chk.sv
module irq_trap_decide_chk #(
  parameter int N_IRQ = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_IRQ-1:0] pend_i,
  input logic [N_IRQ-1:0] en_i,
  input logic [N_IRQ-1:0] deleg_i,
  input logic [1:0]       priv_i,
  input logic             mie_i,
  input logic             recheck_i,
  input logic             take_o,
  input logic [5:0]       cause_o,
  input logic             dpend_o
);

  logic             seen;
  logic [N_IRQ-1:0] pend_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen      <= 1'b0;
      pend_prev <= '0;
    end else begin
      seen      <= 1'b1;
      pend_prev <= pend_i;
    end
  end

  p_gate_closed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (recheck_i && priv_i == 2'b11 && !mie_i) |=> !take_o);

  p_need_pend_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (recheck_i && (pend_i & en_i) == '0) |=> (!take_o && !dpend_o));

  p_deleg_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (recheck_i && (pend_i & en_i & ~deleg_i) == '0) |=> !take_o);

  p_std_listed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && cause_o < 6'd16) |->
      (cause_o inside {6'd11, 6'd3, 6'd7, 6'd9, 6'd1, 6'd5, 6'd13}));

  p_cause_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (int'(cause_o) < N_IRQ));

  p_top_std_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (recheck_i && priv_i != 2'b11 && pend_i[11] && en_i[11] && !deleg_i[11]
     && (pend_i[N_IRQ-1:16] & en_i[N_IRQ-1:16]) == '0) |=> (take_o && cause_o == 6'd11));

  p_pend_edge_wakes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && pend_i != pend_prev && priv_i != 2'b11
     && pend_i[11] && en_i[11] && !deleg_i[11]) |=> take_o);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !recheck_i && pend_i == pend_prev) |=>
      ($stable(take_o) && $stable(cause_o) && $stable(dpend_o)));

  p_idle_cause_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (cause_o == 6'd0));

endmodule

bind irq_trap_decide irq_trap_decide_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pend_i    (pend_i),
  .en_i      (en_i),
  .deleg_i   (deleg_i),
  .priv_i    (priv_i),
  .mie_i     (mie_i),
  .recheck_i (recheck_i),
  .take_o    (take_o),
  .cause_o   (cause_o),
  .dpend_o   (dpend_o)
);

// File: tb/irq_trap_decide_bench.sv
module irq_trap_decide_bench;

  localparam int N = 32;
  localparam logic [1:0] MU = 2'b00, MS = 2'b01, MM = 2'b11;

  typedef struct {
    logic       tk;
    logic [5:0] cs;
    logic       dp;
    string      tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] pend, en, deleg;
  logic [1:0]   priv;
  logic         mie, recheck;
  logic         take;
  logic [5:0]   cause;
  logic         dpend;

  int   n_chk  = 0;
  int   n_fail = 0;
  exp_t sb_q[$];

  logic [N-1:0] m_prev;
  logic         m_tk;
  logic [5:0]   m_cs;
  logic         m_dp;

  always #2 clk = ~clk;

  irq_trap_decide #(.N_IRQ(N)) u_irq_trap_decide (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_i    (pend),
    .en_i      (en),
    .deleg_i   (deleg),
    .priv_i    (priv),
    .mie_i     (mie),
    .recheck_i (recheck),
    .take_o    (take),
    .cause_o   (cause),
    .dpend_o   (dpend)
  );

  // Reference built from the requirements.
  function automatic void ref_eval(input logic [N-1:0] p, e, d, input logic [1:0] pr,
                                   input logic gm, output logic tk,
                                   output logic [5:0] cs, output logic dp);
    logic [N-1:0] el;
    int order [7] = '{11, 3, 7, 9, 1, 5, 13};
    el = p & e & ~d;
    dp = |(p & e & d);
    tk = 1'b0;
    cs = 6'd0;
    if (pr != MM || gm) begin
      for (int i = N - 1; i >= 16; i--)
        if (!tk && el[i]) begin tk = 1'b1; cs = 6'(i); end
      for (int k = 0; k < 7; k++)
        if (!tk && el[order[k]]) begin tk = 1'b1; cs = 6'(order[k]); end
    end
  endfunction

  task automatic apply(input logic [N-1:0] p, e, d, input logic [1:0] pr,
                       input logic gm, input logic rc, input string tag);
    exp_t x;
    @(negedge clk);
    pend = p; en = e; deleg = d; priv = pr; mie = gm; recheck = rc;
    if (rc || p != m_prev) ref_eval(p, e, d, pr, gm, m_tk, m_cs, m_dp);
    m_prev = p;
    x.tk = m_tk; x.cs = m_cs; x.dp = m_dp; x.tag = tag;
    sb_q.push_back(x);
  endtask

  // Monitor: compare one scoreboard item per edge, 1 ns after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t x;
        x = sb_q.pop_front();
        n_chk++;
        if (take !== x.tk || cause !== x.cs || dpend !== x.dp) begin
          n_fail++;
          $display("FAIL %s: actual take=%0b cause=%0d dpend=%0b expected take=%0b cause=%0d dpend=%0b",
                   x.tag, take, cause, dpend, x.tk, x.cs, x.dp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    pend = '0; en = '0; deleg = '0; priv = MM; mie = 1'b0; recheck = 1'b0;
    m_prev = '0; m_tk = 1'b0; m_cs = '0; m_dp = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    n_chk++;
    if (take !== 1'b0 || cause !== 6'd0 || dpend !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 reset: actual take=%0b cause=%0d dpend=%0b expected 0/0/0",
               take, cause, dpend);
    end
    @(negedge clk);
    rst_n = 1'b1;

    apply(32'h0, 32'h0, 32'h0, MM, 1'b0, 1'b0, "R9 idle after reset");
    // R1 privilege gate
    apply(32'h80, 32'h80, 32'h0, MM, 1'b0, 1'b1, "R1 machine, global off");
    apply(32'h80, 32'h80, 32'h0, MM, 1'b1, 1'b1, "R1 machine, global on");
    apply(32'h80, 32'h80, 32'h0, MU, 1'b0, 1'b1, "R1 user ignores global");
    apply(32'h80, 32'h80, 32'h0, MS, 1'b0, 1'b1, "R1 supervisor ignores global");
    // R2 pending and enable both required
    apply(32'h80, 32'h0, 32'h0, MU, 1'b0, 1'b1, "R2 pending not enabled");
    apply(32'h0, 32'h80, 32'h0, MU, 1'b0, 1'b1, "R2 enabled not pending");
    // R3 delegation
    apply(32'h200, 32'h200, 32'h200, MU, 1'b0, 1'b1, "R3 delegated only");
    apply(32'h220, 32'h220, 32'h200, MU, 1'b0, 1'b1, "R3 undelegated sibling");
    apply(32'h200, 32'h200, 32'h200, MM, 1'b1, 1'b1, "R3 delegated in machine mode");
    // R4 ranking, removing the winner each step
    apply(32'h2AAA, 32'hFFFF_FFFF, 32'h0, MU, 1'b0, 1'b1, "R4 all seven");
    apply(32'h22AA, 32'hFFFF_FFFF, 32'h0, MU, 1'b0, 1'b1, "R4 without 11");
    apply(32'h22A2, 32'hFFFF_FFFF, 32'h0, MU, 1'b0, 1'b1, "R4 without 3");
    apply(32'h2222, 32'hFFFF_FFFF, 32'h0, MU, 1'b0, 1'b1, "R4 without 7");
    apply(32'h2022, 32'hFFFF_FFFF, 32'h0, MU, 1'b0, 1'b1, "R4 without 9");
    apply(32'h2020, 32'hFFFF_FFFF, 32'h0, MU, 1'b0, 1'b1, "R4 without 1");
    apply(32'h2000, 32'hFFFF_FFFF, 32'h0, MU, 1'b0, 1'b1, "R4 only 13");
    // R6 unlisted standard bits
    apply(32'hD555, 32'hFFFF_FFFF, 32'h0, MU, 1'b0, 1'b1, "R6 unlisted bits");
    // R5 platform causes
    apply(32'h0010_0800, 32'hFFFF_FFFF, 32'h0, MU, 1'b0, 1'b1, "R5 platform over 11");
    apply(32'h8010_0800, 32'hFFFF_FFFF, 32'h0, MU, 1'b0, 1'b1, "R5 highest platform");
    apply(32'h8010_0800, 32'hFFFF_FFFF, 32'h8000_0000, MU, 1'b0, 1'b1, "R5 top platform delegated");
    // R8 hold without refresh
    apply(32'h80, 32'h80, 32'h0, MU, 1'b0, 1'b1, "R8 setup");
    apply(32'h80, 32'h0, 32'h0, MU, 1'b0, 1'b0, "R8 enable dropped, no recheck");
    apply(32'h80, 32'h0, 32'h80, MM, 1'b0, 1'b0, "R8 mode and mask changed, no recheck");
    apply(32'h80, 32'h0, 32'h80, MM, 1'b0, 1'b1, "R8 recheck refreshes");
    // R7 pending edges refresh on their own
    apply(32'h800, 32'h800, 32'h0, MU, 1'b0, 1'b0, "R7 pending rise, no recheck");
    apply(32'h0, 32'h800, 32'h0, MU, 1'b0, 1'b0, "R7 pending fall, no recheck");
    apply(32'h0, 32'h800, 32'h0, MU, 1'b0, 1'b0, "R9 cause zero when idle");

    @(negedge clk);
    recheck = 1'b0;
    while (sb_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule